// File: doc/BRIEF.md
# Complementary PWM Deadtime Inserter

This block turns one PWM drive level per channel pair into a complementary top/bottom output pair, such as the high-side and low-side switches of a half-bridge. Whenever the level feeding a pair changes, both outputs of that pair are forced low (inactive) for a programmable number of clock cycles. After that delay, the output that matches the new level is driven high. This keeps the two switches from conducting at the same time while one of them is still turning off.

Each pair has a selector in front of its deadtime logic. The selector passes either the PWM generator's signal or a software-supplied level. Any change at the selector output starts a delay, including a change caused by flipping the selector itself. There are three independent pairs by default. They share one deadtime length value, and each pair samples that value when its own interval begins. The outputs feed a later protection stage.

Top module: `deadtime_inserter`

## Requirements
- R1: For each pair, when `swSel[i]` is 1 the pair's source level is `swVal[i]`. When `swSel[i]` is 0 the source level is `pwmIn[i]`. A change on the input that is not selected has no effect on the outputs.
- R2: `topOut[i]` and `botOut[i]` are never both 1 in the same cycle.
- R3: Suppose the source level of a pair is sampled at clock edge t with a value different from the one sampled at edge t-1, and `dtValue` = N > 0. Then both outputs are 0 after edges t through t+N-1. After edge t+N, `topOut` equals the new level and `botOut` equals its inverse.
- R4: A rising change of the source starts a deadtime interval, and so does a falling change. Both intervals have the same length.
- R5: A further change of the source during an interval restarts the count. The outputs stay 0 until N full cycles have passed since the last change.
- R6: With `dtValue` = 0, a source change sampled at edge t gives complementary outputs with the new level after edge t, with no cycle of both outputs low.
- R7: `dtValue` is sampled at the edge that starts an interval. Changing it during the interval does not change that interval's length.
- R8: While `rst` is 1, every output is 0. The first clock edge with `rst` at 0 starts an interval of `dtValue` cycles on every pair. After that interval, each pair shows its current source level.
- R9: Pairs are independent. An interval on one pair does not disturb the outputs of another pair.
- R10: A change of `swSel[i]` starts an interval only if it changes the selected level. If `swVal[i]` equals `pwmIn[i]`, flipping the selector leaves the outputs steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dtValue | input | DT_WIDTH | Deadtime length in clock cycles, shared by all pairs |
| swSel | input | NUM_PAIRS | Per-pair selector: 1 picks the software level |
| swVal | input | NUM_PAIRS | Per-pair software-supplied level |
| pwmIn | input | NUM_PAIRS | Per-pair PWM generator signal |
| topOut | output | NUM_PAIRS | Top (high-side) drive per pair, active high |
| botOut | output | NUM_PAIRS | Bottom (low-side) drive per pair, active high |

## Verification
The function is exercised with several kinds of source pattern:
- Single rising and falling changes with a long deadtime. These separate a correct interval length from an off-by-one count, and show whether both edge directions trigger an interval.
- A change followed by a second change inside the interval. This tells a restarting counter apart from one that finishes the old interval.
- A deadtime length rewritten during an interval, and a zero length. These show when the length is captured, and whether a spurious blank cycle appears.
- Selector flips with equal and unequal levels, and toggles on the input that is not selected. These distinguish a change at the selected level from activity elsewhere.

Throughout every run, the bench also checks the idle pairs, to show the pairs are independent.

// File: rtl/dt_pkg.sv
package dt_pkg;
  // Strobes from a pair's control to its datapath
  typedef struct packed {
    logic blank;  // force both outputs inactive
    logic drive;  // present the current source level on the outputs
  } dtStrobe_t;
endpackage

// File: rtl/dt_pair_datapath.sv
module dt_pair_datapath
  import dt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pwmIn,
  input  logic      swSel,
  input  logic      swVal,
  input  dtStrobe_t strobe,
  output logic      srcChanged,
  output logic      topOut,
  output logic      botOut
);
  logic srcLevel;
  logic srcPrev;

  // Output-control selector ahead of the deadtime logic
  assign srcLevel   = swSel ? swVal : pwmIn;
  assign srcChanged = srcLevel != srcPrev;

  always_ff @(posedge clk) begin
    if (rst) srcPrev <= 1'b0;
    else     srcPrev <= srcLevel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      topOut <= 1'b0;
      botOut <= 1'b0;
    end else if (strobe.blank) begin
      topOut <= 1'b0;
      botOut <= 1'b0;
    end else if (strobe.drive) begin
      topOut <= srcLevel;
      botOut <= ~srcLevel;
    end
  end
endmodule

// File: rtl/dt_pair_ctrl.sv
module dt_pair_ctrl
  import dt_pkg::*;
#(
  parameter int DT_WIDTH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                srcChanged,
  input  logic [DT_WIDTH-1:0] dtValue,
  output dtStrobe_t           strobe
);
  localparam logic [DT_WIDTH-1:0] CNT_ONE  = DT_WIDTH'(1);
  localparam logic [DT_WIDTH-1:0] CNT_ZERO = '0;

  logic [DT_WIDTH-1:0] remaining;
  logic                primed;
  logic                startEvt;

  // Before the first post-reset edge, behave as if the source just changed
  assign startEvt = srcChanged | ~primed;

  always_comb begin
    strobe.blank = startEvt && (dtValue != CNT_ZERO);
    strobe.drive = (startEvt && (dtValue == CNT_ZERO)) ||
                   (!startEvt && (remaining == CNT_ONE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= CNT_ZERO;
      primed    <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (startEvt)                   remaining <= dtValue;
      else if (remaining != CNT_ZERO) remaining <= remaining - CNT_ONE;
    end
  end
endmodule

// File: rtl/deadtime_inserter.sv
module deadtime_inserter
  import dt_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int DT_WIDTH  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DT_WIDTH-1:0]  dtValue,
  input  logic [NUM_PAIRS-1:0] swSel,
  input  logic [NUM_PAIRS-1:0] swVal,
  input  logic [NUM_PAIRS-1:0] pwmIn,
  output logic [NUM_PAIRS-1:0] topOut,
  output logic [NUM_PAIRS-1:0] botOut
);
  for (genvar i = 0; i < NUM_PAIRS; i++) begin : gPair
    dtStrobe_t strobe;
    logic      srcChanged;

    dt_pair_ctrl #(.DT_WIDTH(DT_WIDTH)) uCtrl (
      .clk       (clk),
      .rst       (rst),
      .srcChanged(srcChanged),
      .dtValue   (dtValue),
      .strobe    (strobe)
    );

    dt_pair_datapath uData (
      .clk       (clk),
      .rst       (rst),
      .pwmIn     (pwmIn[i]),
      .swSel     (swSel[i]),
      .swVal     (swVal[i]),
      .strobe    (strobe),
      .srcChanged(srcChanged),
      .topOut    (topOut[i]),
      .botOut    (botOut[i])
    );
  end
endmodule

// File: rtl/deadtime_inserter_chk.sv
module deadtime_inserter_chk #(
  parameter int NUM_PAIRS = 3,
  parameter int DT_WIDTH  = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DT_WIDTH-1:0]  dtValue,
  input logic [NUM_PAIRS-1:0] swSel,
  input logic [NUM_PAIRS-1:0] swVal,
  input logic [NUM_PAIRS-1:0] pwmIn,
  input logic [NUM_PAIRS-1:0] topOut,
  input logic [NUM_PAIRS-1:0] botOut
);
  logic [NUM_PAIRS-1:0] srcNow;
  assign srcNow = (swSel & swVal) | (~swSel & pwmIn);

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (topOut & botOut) == '0);

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (topOut == '0) && (botOut == '0));

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : gChk
    // R3
    blank_on_change_chk: assert property (@(posedge clk) disable iff (rst)
      ((srcNow[i] != $past(srcNow[i])) && (dtValue != '0)) |=> (!topOut[i] && !botOut[i]));

    // R3
    top_rise_level_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(topOut[i]) |-> $past(srcNow[i]));

    // R3
    bot_rise_level_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(botOut[i]) |-> !$past(srcNow[i]));
  end
endmodule

bind deadtime_inserter deadtime_inserter_chk #(
  .NUM_PAIRS(NUM_PAIRS),
  .DT_WIDTH (DT_WIDTH)
) uChk (
  .clk    (clk),
  .rst    (rst),
  .dtValue(dtValue),
  .swSel  (swSel),
  .swVal  (swVal),
  .pwmIn  (pwmIn),
  .topOut (topOut),
  .botOut (botOut)
);

// File: tb/tb_deadtime_inserter.sv
module tb_deadtime_inserter;
  localparam int NP = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] dtValue;
  logic [NP-1:0] swSel, swVal, pwmIn;
  logic [NP-1:0] topOut, botOut;
  logic [NP-1:0] lvl;
  int            vecCnt = 0;
  int            errCnt = 0;
  bit            done   = 1'b0;

  always #2.5 clk = ~clk;

  deadtime_inserter #(.NUM_PAIRS(NP), .DT_WIDTH(DW)) dut (
    .clk(clk), .rst(rst), .dtValue(dtValue), .swSel(swSel),
    .swVal(swVal), .pwmIn(pwmIn), .topOut(topOut), .botOut(botOut)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectPair(int p, logic eT, logic eB, string tag);
    vecCnt++;
    if (topOut[p] !== eT || botOut[p] !== eB) begin
      errCnt++;
      $display("FAIL %s pair %0d: top/bot=%b%b expected %b%b", tag, p, topOut[p], botOut[p], eT, eB);
    end
    vecCnt++;
    if ((topOut[p] & botOut[p]) !== 1'b0) begin
      errCnt++;
      $display("FAIL R2 pair %0d: overlap top/bot=%b%b expected not both 1", p, topOut[p], botOut[p]);
    end
  endtask

  task automatic othersSteady(int p);
    for (int q = 0; q < NP; q++)
      if (q != p) expectPair(q, lvl[q], ~lvl[q], "R9");
  endtask

  // n cycles of both low, then the settled level in lvl[p]
  task automatic blankRun(int p, int n, string tag);
    for (int k = 0; k < n; k++) begin
      step();
      expectPair(p, 1'b0, 1'b0, tag);
      othersSteady(p);
    end
    step();
    expectPair(p, lvl[p], ~lvl[p], tag);
    othersSteady(p);
  endtask

  task automatic testReset();
    rst = 1'b1; dtValue = 8'd3; swSel = '0; swVal = '0; pwmIn = '0;
    repeat (3) step();
    for (int p = 0; p < NP; p++) expectPair(p, 1'b0, 1'b0, "R8");
    rst = 1'b0; lvl = '0;
    for (int k = 0; k < 3; k++) begin
      step();
      for (int p = 0; p < NP; p++) expectPair(p, 1'b0, 1'b0, "R8");
    end
    step();
    for (int p = 0; p < NP; p++) expectPair(p, lvl[p], ~lvl[p], "R8");
  endtask

  task automatic testEdges();
    dtValue = 8'd4;
    pwmIn[0] = 1'b1; lvl[0] = 1'b1;
    blankRun(0, 4, "R3");
    pwmIn[0] = 1'b0; lvl[0] = 1'b0;
    blankRun(0, 4, "R4");
  endtask

  task automatic testZero();
    dtValue = 8'd0;
    pwmIn[1] = 1'b1; lvl[1] = 1'b1;
    blankRun(1, 0, "R6");
    pwmIn[1] = 1'b0; lvl[1] = 1'b0;
    blankRun(1, 0, "R6");
  endtask

  task automatic testRetrigger();
    dtValue = 8'd5;
    pwmIn[0] = 1'b1;
    step(); expectPair(0, 1'b0, 1'b0, "R5");
    step(); expectPair(0, 1'b0, 1'b0, "R5");
    pwmIn[0] = 1'b0; lvl[0] = 1'b0;
    blankRun(0, 5, "R5");
  endtask

  task automatic testDtSample();
    dtValue = 8'd3;
    pwmIn[2] = 1'b1; lvl[2] = 1'b1;
    step(); expectPair(2, 1'b0, 1'b0, "R7");
    dtValue = 8'd10;
    step(); expectPair(2, 1'b0, 1'b0, "R7");
    step(); expectPair(2, 1'b0, 1'b0, "R7");
    step(); expectPair(2, 1'b1, 1'b0, "R7");
  endtask

  task automatic testMux();
    dtValue = 8'd2;
    swVal[2] = 1'b0; swSel[2] = 1'b1; lvl[2] = 1'b0;
    blankRun(2, 2, "R10");
    pwmIn[2] = 1'b0;
    repeat (4) begin step(); expectPair(2, 1'b0, 1'b1, "R1"); end
    swVal[2] = 1'b1; lvl[2] = 1'b1;
    blankRun(2, 2, "R1");
    pwmIn[2] = 1'b1;
    repeat (2) begin step(); expectPair(2, 1'b1, 1'b0, "R1"); end
    swSel[2] = 1'b0;
    repeat (3) begin step(); expectPair(2, 1'b1, 1'b0, "R10"); end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: run incomplete, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    testReset();
    testEdges();
    testZero();
    testRetrigger();
    testDtSample();
    testMux();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule